// File: doc/BRIEF.md
# Hall-sensor six-step commutation decoder

This block turns three Hall logic bits from a brushless motor into the six gate enables of a three-phase bridge, using 120-degree excitation. Each Hall bit is 1 when its sensor's positive input exceeds its negative input. The bits pass through a synchronizer. They are then decoded into one conducting high-side phase and one conducting low-side phase. A direction input selects the excitation order. The gate enables are registered on the system clock.

The high-side enables drive P-channel devices and are active low. A released high-side output reads as 1. The low-side enables are active high. The gating is asymmetric. PWM chopping, overcurrent cut-off and lock cut-off force only the low side off, and the high side keeps following the rotor. A thermal or undervoltage fault, or a Hall code with all bits equal, releases every high side and pulls every low side low. A tachometer output follows one Hall bit, so it toggles at a rate proportional to speed.

Top module: `hall_commutator`

## Requirements
- R1: While `rst_n` is low, `upper_n` is 3'b111, `lower` is 3'b000 and `tach` is 0.
- R2: With `dir_rev`=0 and no gating, `hall_in` maps as follows. Bit i of each port belongs to phase i (0=A, 1=B, 2=C), and in `upper_n` the active phase is 0. The codes 001, 011, 010, 110, 100 and 101 give high-side phases A, B, B, C, C and A. The same codes give low-side phases C, C, A, A, B and B.
- R3: With `dir_rev`=1, the high-side and low-side phase of every valid code are swapped relative to R2.
- R4: `hall_in` values 000 and 111 give `upper_n`=3'b111 and `lower`=3'b000.
- R5: `fault_off`=1 gives `upper_n`=3'b111 and `lower`=3'b000, whatever the other inputs are.
- R6: `pwm_on`=0 forces `lower` to 3'b000, while `upper_n` still follows the decode.
- R7: `ocp_off`=1 forces `lower` to 3'b000, while `upper_n` still follows the decode.
- R8: `lock_off`=1 forces `lower` to 3'b000, while `upper_n` still follows the decode.
- R9: At most one bit of `upper_n` is 0 and at most one bit of `lower` is 1, and they never belong to the same phase.
- R10: A change on `hall_in` reaches the outputs on the SYNC_STAGES+1-th rising edge. A change on a gating flag reaches them on the next rising edge.
- R11: `tach` equals bit TACH_BIT of `hall_in`, delayed by SYNC_STAGES+1 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_in | input | 3 | Asynchronous Hall bits, bit i = phase i |
| dir_rev | input | 1 | 0 = forward order, 1 = reverse order |
| pwm_on | input | 1 | PWM chop phase; 0 turns the low side off |
| ocp_off | input | 1 | Overcurrent cut-off of the low side |
| lock_off | input | 1 | Lock-protection cut-off of the low side |
| fault_off | input | 1 | Thermal or undervoltage fault; all gates off |
| upper_n | output | 3 | High-side enables, active low |
| lower | output | 3 | Low-side enables, active high |
| tach | output | 1 | Speed pulse following one Hall bit |

## Verification
The bench builds the block with its defaults: two synchronizer stages and the tachometer on bit 0. With these values the total Hall-to-output latency is three edges. A flag-to-output latency of one edge can be probed exactly at the boundary cycles. All six valid codes are walked in both directions. Each gating flag is raised against a live code, so the high side can be seen still moving while the low side is held off. Fault is applied together with active gating and with invalid codes to confirm its priority.

// File: rtl/hc_pkg.sv
package hc_pkg;
   localparam int unsigned NPH = 3;
   typedef logic [NPH-1:0] phase_vec_t;
endpackage

// File: rtl/hc_sync.sv
module hc_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("hc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d_async;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hc_decode.sv
module hc_decode
   import hc_pkg::*;
(
   input  phase_vec_t code,
   input  logic       rev,
   output phase_vec_t hi_sel,
   output phase_vec_t lo_sel,
   output logic       bad_code
);
   phase_vec_t fwd_hi;
   phase_vec_t fwd_lo;

   genvar p;
   generate
      for (p = 0; p < NPH; p++) begin : g_phase
         localparam int unsigned NXT = (p + 1) % NPH;
         assign fwd_hi[p] =  code[p] & ~code[NXT];
         assign fwd_lo[p] = ~code[p] &  code[NXT];
      end
   endgenerate

   assign bad_code = (&code) | ~(|code);
   assign hi_sel   = rev ? fwd_lo : fwd_hi;
   assign lo_sel   = rev ? fwd_hi : fwd_lo;
endmodule

// File: rtl/hc_gate.sv
module hc_gate
   import hc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  phase_vec_t hi_sel,
   input  phase_vec_t lo_sel,
   input  logic       bad_code,
   input  logic       pwm_on,
   input  logic       ocp_off,
   input  logic       lock_off,
   input  logic       fault_off,
   input  logic       tach_src,
   output phase_vec_t upper_n,
   output phase_vec_t lower,
   output logic       tach
);
   logic all_off;
   logic low_cut;

   assign all_off = fault_off | bad_code;
   assign low_cut = ~pwm_on | ocp_off | lock_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_n <= '1;
         lower   <= '0;
         tach    <= 1'b0;
      end else begin
         tach <= tach_src;
         if (all_off) begin
            upper_n <= '1;
            lower   <= '0;
         end else begin
            upper_n <= ~hi_sel;
            lower   <= low_cut ? '0 : lo_sel;
         end
      end
   end

   assert_fault_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_off |=> (upper_n == '1 && lower == '0));
   assert_bad_code_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bad_code |=> (upper_n == '1 && lower == '0));
   assert_pwm_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_on |=> (lower == '0));
   assert_ocp_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ocp_off |=> (lower == '0));
   assert_lock_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_off |=> (lower == '0));
   assert_one_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot0(~upper_n) && $onehot0(lower) && ((~upper_n & lower) == '0)));
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TACH_BIT    = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall_in,
   input  logic       dir_rev,
   input  logic       pwm_on,
   input  logic       ocp_off,
   input  logic       lock_off,
   input  logic       fault_off,
   output logic [2:0] upper_n,
   output logic [2:0] lower,
   output logic       tach
);
   import hc_pkg::*;

   generate
      if (TACH_BIT >= NPH) begin : g_bad_tach
         $error("hall_commutator: TACH_BIT out of range");
      end
   endgenerate

   phase_vec_t hall_s;
   phase_vec_t hi_sel;
   phase_vec_t lo_sel;
   logic       bad_code;

   hc_sync #(.STAGES(SYNC_STAGES), .WIDTH(NPH)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(hall_in), .q_sync(hall_s)
   );

   hc_decode u_decode (
      .code(hall_s), .rev(dir_rev),
      .hi_sel(hi_sel), .lo_sel(lo_sel), .bad_code(bad_code)
   );

   hc_gate u_gate (
      .clk(clk), .rst_n(rst_n),
      .hi_sel(hi_sel), .lo_sel(lo_sel), .bad_code(bad_code),
      .pwm_on(pwm_on), .ocp_off(ocp_off), .lock_off(lock_off),
      .fault_off(fault_off), .tach_src(hall_s[TACH_BIT]),
      .upper_n(upper_n), .lower(lower), .tach(tach)
   );

   assert_tach_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tach == $past(hall_s[TACH_BIT])));
endmodule

// File: tb/hall_commutator_tb.sv
module hall_commutator_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall_in = 3'b000;
   logic       dir_rev = 1'b0;
   logic       pwm_on = 1'b1;
   logic       ocp_off = 1'b0;
   logic       lock_off = 1'b0;
   logic       fault_off = 1'b0;
   logic [2:0] upper_n;
   logic [2:0] lower;
   logic       tach;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   hall_commutator u_dut (
      .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_rev(dir_rev),
      .pwm_on(pwm_on), .ocp_off(ocp_off), .lock_off(lock_off),
      .fault_off(fault_off), .upper_n(upper_n), .lower(lower), .tach(tach)
   );

   // expected one-hot phases in forward order (bit i = phase i)
   function automatic logic [2:0] fwd_high(input logic [2:0] c);
      case (c)
         3'b001: return 3'b001;
         3'b011: return 3'b010;
         3'b010: return 3'b010;
         3'b110: return 3'b100;
         3'b100: return 3'b100;
         3'b101: return 3'b001;
         default: return 3'b000;
      endcase
   endfunction

   function automatic logic [2:0] fwd_low(input logic [2:0] c);
      case (c)
         3'b001: return 3'b100;
         3'b011: return 3'b100;
         3'b010: return 3'b001;
         3'b110: return 3'b001;
         3'b100: return 3'b010;
         3'b101: return 3'b010;
         default: return 3'b000;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      cycles(2);
      chk("R1 upper_n in reset", upper_n, 3'b111);
      chk("R1 lower in reset", lower, 3'b000);
      chk("R1 tach in reset", {2'b00, tach}, 3'b000);
      rst_n = 1'b1;
      cycles(2);
   endtask

   task automatic t_walk(input logic rev);
      logic [2:0] seq [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
      dir_rev = rev;
      for (int k = 0; k < 6; k++) begin
         hall_in = seq[k];
         cycles(4);
         if (!rev) begin
            chk("R2 forward upper_n", upper_n, ~fwd_high(seq[k]));
            chk("R2 forward lower", lower, fwd_low(seq[k]));
         end else begin
            chk("R3 reverse upper_n", upper_n, ~fwd_low(seq[k]));
            chk("R3 reverse lower", lower, fwd_high(seq[k]));
         end
         chk("R9 no shared phase", ~upper_n & lower, 3'b000);
      end
      dir_rev = 1'b0;
   endtask

   task automatic t_invalid;
      hall_in = 3'b000; cycles(4);
      chk("R4 code 000 upper_n", upper_n, 3'b111);
      chk("R4 code 000 lower", lower, 3'b000);
      hall_in = 3'b111; dir_rev = 1'b1; cycles(4);
      chk("R4 code 111 upper_n", upper_n, 3'b111);
      chk("R4 code 111 lower", lower, 3'b000);
      dir_rev = 1'b0;
   endtask

   task automatic t_fault;
      hall_in = 3'b010; cycles(4);
      fault_off = 1'b1; cycles(1);
      chk("R5 fault upper_n", upper_n, 3'b111);
      chk("R5 fault lower", lower, 3'b000);
      ocp_off = 1'b1; pwm_on = 1'b0; cycles(2);
      chk("R5 fault with gating upper_n", upper_n, 3'b111);
      fault_off = 1'b0; ocp_off = 1'b0; pwm_on = 1'b1; cycles(1);
      chk("R5 fault released upper_n", upper_n, ~fwd_high(3'b010));
      chk("R5 fault released lower", lower, fwd_low(3'b010));
   endtask

   task automatic t_low_cuts;
      hall_in = 3'b110; cycles(4);
      pwm_on = 1'b0; cycles(1);
      chk("R6 pwm off lower", lower, 3'b000);
      hall_in = 3'b100; cycles(3);
      chk("R6 pwm off upper_n follows", upper_n, ~fwd_high(3'b100));
      pwm_on = 1'b1; ocp_off = 1'b1; cycles(1);
      chk("R7 ocp lower", lower, 3'b000);
      chk("R7 ocp upper_n", upper_n, ~fwd_high(3'b100));
      ocp_off = 1'b0; lock_off = 1'b1; dir_rev = 1'b1; hall_in = 3'b011; cycles(4);
      chk("R8 lock lower", lower, 3'b000);
      chk("R8 lock upper_n", upper_n, ~fwd_low(3'b011));
      lock_off = 1'b0; cycles(1);
      chk("R8 lock released lower", lower, fwd_high(3'b011));
      dir_rev = 1'b0;
   endtask

   task automatic t_latency;
      hall_in = 3'b010; cycles(4);
      hall_in = 3'b001; cycles(2);
      chk("R10 hall after two edges", upper_n, ~fwd_high(3'b010));
      chk("R11 tach after two edges", {2'b00, tach}, 3'b000);
      cycles(1);
      chk("R10 hall after three edges", upper_n, ~fwd_high(3'b001));
      chk("R11 tach after three edges", {2'b00, tach}, 3'b001);
      ocp_off = 1'b1; cycles(1);
      chk("R10 flag after one edge", lower, 3'b000);
      ocp_off = 1'b0; cycles(1);
      chk("R10 flag cleared after one edge", lower, fwd_low(3'b001));
   endtask

   initial begin
      t_reset();
      t_walk(1'b0);
      t_walk(1'b1);
      t_invalid();
      t_fault();
      t_low_cuts();
      t_latency();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=running expected=finished");
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule